// File: doc/BRIEF.md
# Cascaded Second-Level Interrupt Aggregator

This block sits between up to 32 level-sensitive interrupt sources and a parent interrupt controller. Each group of source lines is described by a map-mask parameter. For every group, the block drives one parent request that is the OR of the lines in that group, after each line is qualified by a per-line enable bit. Source positions that no map mask names, and that are not forward-capable, are not connected. They have no effect anywhere and read back as zero.

The lowest `NUM_FWD` lines are forward-capable, and `NUM_FWD` must be at least 1. Each of these lines has a steering gate set by one bit of a forward mask. When the bit is set, the line drives its own dedicated parent output directly, with no register in the path. It then plays no part in the enable, status, grouping or wake logic. When the bit is clear, the line is aggregated like any other line.

Software reaches the block through an 8-byte window of two 32-bit words:

- **Offset 0x0** holds the enable bits.
- **Offset 0x4** reads as the raw connected-line status. A write to 0x4 loads the forward mask.

An optional wake request reports any enabled, aggregated line that is active.

Top module: `irq_cascade_agg`

## Requirements
- R1: After a synchronous active-high reset, the enable word is zero and `parent_irq_o` and `wake_o` are low. The forward mask equals `FWD_INIT` limited to the forward-capable bits; by default this is 0x7, so lines 0, 1 and 2 are forwarded.
- R2: A write at byte offset 0x0 stores the enable word, where bit n = 1 enables line n. A read at 0x0 returns the stored word with every unconnected position zero. The connected set is the union of all map masks and bits 0..NUM_FWD-1, which is 0x00000FFF by default.
- R3: A read at offset 0x4 returns `irq_i` with the unconnected positions and the currently forwarded lines cleared. The enable word has no effect on this read.
- R4: A write at offset 0x4 loads the forward mask, and only bits below `NUM_FWD` are kept. A write at any other offset (0x1-0x3, 0x5-0x7) changes nothing, and a read at those offsets returns zero.
- R5: `parent_irq_o[k]` is high in the cycle after a clock edge at which some line was high, enabled, not forwarded and set in `MAP_MASKS[k]`.
  - Default group 0 is 0x00000EBF: lines 0-5, 7 and 9-11.
  - Default group 1 is 0x00000140: lines 6 and 8.
- R6: `fwd_irq_o[j]` equals `irq_i[j]` combinationally while forward bit j is 1, and is 0 while forward bit j is 0. In the second case line j joins the groups its map masks name.
- R7: A forwarded line has no effect on the grouped outputs, the status read or `wake_o`, whatever its enable bit holds.
- R8: A line at an unconnected position (default: lines 12-31) never changes any output or any read-back value.
- R9: With `WAKE_CAPABLE` = 1, `wake_o` is high in the cycle after an edge at which any enabled, connected, non-forwarded line was high. With `WAKE_CAPABLE` = 0, `wake_o` stays low.
- R10: A write to the enable word or the forward mask is first seen by the registered outputs one cycle after the edge that takes the write. During the cycle right after that edge, the registered outputs still reflect the old setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| irq_i | input | 32 | Level-sensitive source lines |
| cfg_wr_i | input | 1 | Write strobe for the register window |
| cfg_addr_i | input | 3 | Byte offset into the register window |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Read data for `cfg_addr_i` (combinational) |
| parent_irq_o | output | NUM_PARENTS | Registered grouped parent requests |
| fwd_irq_o | output | NUM_FWD | Dedicated outputs of the forwarded lines |
| wake_o | output | 1 | Registered wake request |

## Verification
Two things can land in the same clock: a register write that reconfigures steering or enables, and a change of the source lines that this write affects. The bench provokes this by rewriting the forward mask in the very cycle a forward-capable line rises, and by enabling a line in the same cycle it goes high. The behavioural model samples the inputs at each rising edge using the configuration held before that edge, and only then applies the write. Every falling edge compares the grouped outputs, the wake request, the forwarded outputs and the read data against that model. A design that applies a new setting one cycle early or one cycle late disagrees with it.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int unsigned LINE_W     = 32;
    localparam int unsigned CFG_ADDR_W = 3;

    typedef logic [LINE_W-1:0]     line_vec_t;
    typedef logic [CFG_ADDR_W-1:0] cfg_addr_t;

    // Byte offsets inside the 8-byte window
    localparam cfg_addr_t OFS_ENABLE = 3'h0;
    localparam cfg_addr_t OFS_STATUS = 3'h4;

    // Software-visible configuration kept by the register file
    typedef struct packed {
        line_vec_t en;
        line_vec_t fwd;
    } cfg_state_t;

    // Vector with the n lowest bits set
    function automatic line_vec_t low_ones(input int unsigned n);
        line_vec_t v;
        v = '0;
        for (int unsigned i = 0; i < LINE_W; i++) begin
            if (i < n) v[i] = 1'b1;
        end
        return v;
    endfunction

endpackage

// File: rtl/irq_agg_regs.sv
module irq_agg_regs
    import irq_agg_pkg::*;
#(
    parameter line_vec_t CONN_MASK    = '0,
    parameter line_vec_t FWD_CAP_MASK = '0,
    parameter line_vec_t FWD_INIT     = '0
) (
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      cfg_wr_i,
    input  cfg_addr_t cfg_addr_i,
    input  line_vec_t cfg_wdata_i,
    input  line_vec_t retained_i,
    output line_vec_t cfg_rdata_o,
    output line_vec_t en_o,
    output line_vec_t fwd_o
);

    localparam cfg_state_t RESET_STATE = '{en: '0, fwd: FWD_INIT & FWD_CAP_MASK};

    cfg_state_t st_d, st_q;
    line_vec_t  status;

    // Next-state computation for the configuration words
    always_comb begin
        st_d = st_q;
        if (cfg_wr_i) begin
            if (cfg_addr_i == OFS_ENABLE) begin
                st_d.en = cfg_wdata_i & CONN_MASK;
            end else if (cfg_addr_i == OFS_STATUS) begin
                st_d.fwd = cfg_wdata_i & FWD_CAP_MASK;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= RESET_STATE;
        end else begin
            st_q <= st_d;
        end
    end

    // Forwarded lines are already removed from retained_i
    assign status = retained_i & CONN_MASK;

    always_comb begin
        if (cfg_addr_i == OFS_ENABLE) begin
            cfg_rdata_o = st_q.en;
        end else if (cfg_addr_i == OFS_STATUS) begin
            cfg_rdata_o = status;
        end else begin
            cfg_rdata_o = '0;
        end
    end

    assign en_o  = st_q.en;
    assign fwd_o = st_q.fwd;

endmodule

// File: rtl/irq_agg_fwd.sv
module irq_agg_fwd
    import irq_agg_pkg::*;
#(
    parameter int unsigned NUM_FWD = 3
) (
    input  line_vec_t          line_i,
    input  line_vec_t          sel_i,
    output logic [NUM_FWD-1:0] steer_o,
    output line_vec_t          retained_o
);

    // One steering gate per forward-capable line; other lines pass straight through
    for (genvar j = 0; j < LINE_W; j++) begin : g_line
        if (j < NUM_FWD) begin : g_gate
            assign steer_o[j]    = line_i[j] & sel_i[j];
            assign retained_o[j] = line_i[j] & ~sel_i[j];
        end else begin : g_pass
            assign retained_o[j] = line_i[j];
        end
    end

endmodule

// File: rtl/irq_agg_group.sv
module irq_agg_group
    import irq_agg_pkg::*;
#(
    parameter int unsigned                         NUM_PARENTS  = 2,
    parameter logic [NUM_PARENTS-1:0][LINE_W-1:0] MAP_MASKS    = '0,
    parameter bit                                  WAKE_CAPABLE = 1'b1
) (
    input  logic                   clk_i,
    input  logic                   rst_i,
    input  line_vec_t              live_i,
    output logic [NUM_PARENTS-1:0] parent_o,
    output logic                   wake_o
);

    typedef struct packed {
        logic [NUM_PARENTS-1:0] par;
        logic                   wake;
    } grp_state_t;

    grp_state_t             st_d, st_q;
    logic [NUM_PARENTS-1:0] hit;
    logic                   wake_hit;

    // One OR tree per parent output
    for (genvar k = 0; k < NUM_PARENTS; k++) begin : g_parent
        assign hit[k] = |(live_i & MAP_MASKS[k]);
    end

    if (WAKE_CAPABLE) begin : g_wake
        assign wake_hit = |live_i;
    end else begin : g_nowake
        assign wake_hit = 1'b0;
    end

    always_comb begin
        st_d      = st_q;
        st_d.par  = hit;
        st_d.wake = wake_hit;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign parent_o = st_q.par;
    assign wake_o   = st_q.wake;

endmodule

// File: rtl/irq_cascade_agg.sv
module irq_cascade_agg
    import irq_agg_pkg::*;
#(
    parameter int unsigned                     NUM_PARENTS  = 2,
    parameter logic [NUM_PARENTS-1:0][31:0]    MAP_MASKS    = {32'h0000_0140, 32'h0000_0EBF},
    parameter int unsigned                     NUM_FWD      = 3,
    parameter logic [31:0]                     FWD_INIT     = 32'h0000_0007,
    parameter bit                              WAKE_CAPABLE = 1'b1
) (
    input  logic                   clk_i,
    input  logic                   rst_i,
    input  logic [31:0]            irq_i,
    input  logic                   cfg_wr_i,
    input  logic [2:0]             cfg_addr_i,
    input  logic [31:0]            cfg_wdata_i,
    output logic [31:0]            cfg_rdata_o,
    output logic [NUM_PARENTS-1:0] parent_irq_o,
    output logic [NUM_FWD-1:0]     fwd_irq_o,
    output logic                   wake_o
);

    function automatic line_vec_t fold_maps();
        line_vec_t acc;
        acc = '0;
        for (int unsigned k = 0; k < NUM_PARENTS; k++) begin
            acc = acc | MAP_MASKS[k];
        end
        return acc;
    endfunction

    localparam line_vec_t FWD_CAP_MASK = low_ones(NUM_FWD);
    localparam line_vec_t CONN_MASK    = fold_maps() | FWD_CAP_MASK;

    line_vec_t en_vec;
    line_vec_t fwd_vec;
    line_vec_t retained;
    line_vec_t live;

    irq_agg_fwd #(
        .NUM_FWD (NUM_FWD)
    ) u_fwd (
        .line_i     (irq_i),
        .sel_i      (fwd_vec),
        .steer_o    (fwd_irq_o),
        .retained_o (retained)
    );

    irq_agg_regs #(
        .CONN_MASK    (CONN_MASK),
        .FWD_CAP_MASK (FWD_CAP_MASK),
        .FWD_INIT     (FWD_INIT)
    ) u_regs (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .cfg_wr_i    (cfg_wr_i),
        .cfg_addr_i  (cfg_addr_i),
        .cfg_wdata_i (cfg_wdata_i),
        .retained_i  (retained),
        .cfg_rdata_o (cfg_rdata_o),
        .en_o        (en_vec),
        .fwd_o       (fwd_vec)
    );

    // The enable word only holds connected bits
    assign live = retained & en_vec;

    irq_agg_group #(
        .NUM_PARENTS  (NUM_PARENTS),
        .MAP_MASKS    (MAP_MASKS),
        .WAKE_CAPABLE (WAKE_CAPABLE)
    ) u_group (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .live_i   (live),
        .parent_o (parent_irq_o),
        .wake_o   (wake_o)
    );

endmodule

// File: rtl/irq_agg_checker.sv
module irq_agg_checker #(
    parameter int unsigned                  NUM_PARENTS = 2,
    parameter logic [NUM_PARENTS-1:0][31:0] MAP_MASKS   = '0,
    parameter int unsigned                  NUM_FWD     = 3,
    parameter logic [31:0]                  CONN_MASK   = '0
) (
    input logic                   clk_i,
    input logic                   rst_i,
    input logic [31:0]            irq_i,
    input logic                   cfg_wr_i,
    input logic [2:0]             cfg_addr_i,
    input logic [31:0]            cfg_rdata_o,
    input logic [NUM_PARENTS-1:0] parent_irq_o,
    input logic [NUM_FWD-1:0]     fwd_irq_o,
    input logic                   wake_o
);

    AST_RESET_QUIET: assert property (@(posedge clk_i)
        rst_i |=> (parent_irq_o == '0 && !wake_o));                                   // R1

    AST_ENABLE_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(!cfg_wr_i) && cfg_addr_i == 3'h0 && $past(cfg_addr_i) == 3'h0)
            |-> $stable(cfg_rdata_o));                                                 // R2

    AST_FWD_NEEDS_LINE: assert property (@(posedge clk_i) disable iff (rst_i)
        (fwd_irq_o & ~irq_i[NUM_FWD-1:0]) == '0);                                      // R6

    AST_UNCONN_READS_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        (cfg_rdata_o & ~CONN_MASK) == '0);                                             // R8

    AST_WAKE_HAS_SOURCE: assert property (@(posedge clk_i) disable iff (rst_i)
        wake_o |-> $past(|(irq_i & CONN_MASK)));                                       // R9

    for (genvar k = 0; k < NUM_PARENTS; k++) begin : g_par_chk
        AST_PARENT_HAS_SOURCE: assert property (@(posedge clk_i) disable iff (rst_i)
            parent_irq_o[k] |-> $past(|(irq_i & MAP_MASKS[k])));                       // R5
    end

endmodule

bind irq_cascade_agg irq_agg_checker #(
    .NUM_PARENTS (NUM_PARENTS),
    .MAP_MASKS   (MAP_MASKS),
    .NUM_FWD     (NUM_FWD),
    .CONN_MASK   (CONN_MASK)
) u_chk (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .irq_i        (irq_i),
    .cfg_wr_i     (cfg_wr_i),
    .cfg_addr_i   (cfg_addr_i),
    .cfg_rdata_o  (cfg_rdata_o),
    .parent_irq_o (parent_irq_o),
    .fwd_irq_o    (fwd_irq_o),
    .wake_o       (wake_o)
);

// File: tb/irq_cascade_agg_tb_top.sv
module irq_cascade_agg_tb_top;

    localparam logic [31:0] GRP0  = 32'h0000_0EBF;
    localparam logic [31:0] GRP1  = 32'h0000_0140;
    localparam logic [31:0] CONN  = 32'h0000_0FFF;
    localparam logic [31:0] FCAP  = 32'h0000_0007;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] irq = '0;
    logic        wr = 1'b0;
    logic [2:0]  addr = 3'h0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  parent;
    logic [2:0]  fwd_out;
    logic        wake;

    int n_checks = 0;
    int n_fail   = 0;
    bit mon_on   = 1'b0;
    bit done     = 1'b0;

    // Behavioural reference state
    logic [31:0] m_en, m_fwd;
    logic [1:0]  e_par;
    logic        e_wake;

    always #5 clk = ~clk;

    irq_cascade_agg dut_i (
        .clk_i        (clk),
        .rst_i        (rst),
        .irq_i        (irq),
        .cfg_wr_i     (wr),
        .cfg_addr_i   (addr),
        .cfg_wdata_i  (wdata),
        .cfg_rdata_o  (rdata),
        .parent_irq_o (parent),
        .fwd_irq_o    (fwd_out),
        .wake_o       (wake)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h t=%0t", tag, got, exp, $time);
        end
    endtask

    // Model: sample with the old configuration, then apply the write
    always @(posedge clk) begin
        logic [31:0] act;
        if (rst) begin
            m_en = '0; m_fwd = FCAP; e_par = '0; e_wake = 1'b0;
        end else begin
            act      = irq & m_en & CONN & ~m_fwd;
            e_par[0] = |(act & GRP0);
            e_par[1] = |(act & GRP1);
            e_wake   = |act;
            if (wr && addr == 3'h0) m_en  = wdata & CONN;
            if (wr && addr == 3'h4) m_fwd = wdata & FCAP;
        end
    end

    function automatic logic [31:0] model_read();
        if (addr == 3'h0) return m_en;
        if (addr == 3'h4) return irq & CONN & ~m_fwd;
        return '0;
    endfunction

    // Every-cycle comparison, away from the rising edge
    always @(negedge clk) begin
        if (mon_on && !rst) begin
            chk("R5/R7/R10 parent", {30'd0, parent}, {30'd0, e_par});
            chk("R9 wake", {31'd0, wake}, {31'd0, e_wake});
            chk("R6 fwd_out", {29'd0, fwd_out}, {29'd0, irq[2:0] & m_fwd[2:0]});
            chk("R2/R3/R4 rdata", rdata, model_read());
        end
    end

    task automatic drive_irq(input logic [31:0] v);
        @(posedge clk); #2; irq = v;
    endtask

    task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk); #2; wr = 1'b1; addr = a; wdata = d;
        @(posedge clk); #2; wr = 1'b0;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
        #1;
    endtask

    initial begin
        logic [31:0] lfsr;
        repeat (3) @(posedge clk);
        #2; rst = 1'b0; mon_on = 1'b1;
        @(negedge clk); #1;
        // R1: reset state
        chk("R1 enable after reset", rdata, 32'h0);
        chk("R1 parent after reset", {30'd0, parent}, 32'h0);
        chk("R1 wake after reset", {31'd0, wake}, 32'h0);
        drive_irq(32'h1); @(negedge clk); #1;
        chk("R1 line0 forwarded at reset", {29'd0, fwd_out}, 32'h1);

        // R2: enable write, read back masked
        cfg_write(3'h0, 32'hFFFF_FFFF); @(negedge clk); #1;
        chk("R2 enable readback", rdata, 32'h0000_0FFF);
        settle();
        chk("R7 forwarded line0 no group", {30'd0, parent}, 32'h0);
        addr = 3'h4; #1;
        chk("R7 forwarded line0 no status", rdata, 32'h0);

        // R5: group 0 and group 1
        drive_irq(32'h10); settle();
        chk("R5 line4 to group0", {30'd0, parent}, 32'h1);
        drive_irq(32'h40); settle();
        chk("R5 line6 to group1", {30'd0, parent}, 32'h2);
        chk("R3 status line6", rdata, 32'h40);

        // R8: unconnected lines
        drive_irq(32'hFFFF_F000); settle();
        chk("R8 unconnected parent", {30'd0, parent}, 32'h0);
        chk("R8 unconnected wake", {31'd0, wake}, 32'h0);
        chk("R8 unconnected status", rdata, 32'h0);

        // R4/R6: unforward, line1 joins group 0
        cfg_write(3'h4, 32'h0);
        drive_irq(32'h2); settle(); addr = 3'h4; #1;
        chk("R6 unforwarded line1 no dedicated out", {29'd0, fwd_out}, 32'h0);
        chk("R6 unforwarded line1 in group0", {30'd0, parent}, 32'h1);
        chk("R3 status line1", rdata, 32'h2);

        // R4: stray offset ignored, forward mask truncated
        cfg_write(3'h2, 32'h0); addr = 3'h0; #1;
        chk("R4 stray write ignored", rdata, 32'h0000_0FFF);
        addr = 3'h6; #1;
        chk("R4 stray offset reads zero", rdata, 32'h0);
        cfg_write(3'h4, 32'hFFFF_FFFF);
        drive_irq(32'hF); settle();
        chk("R4 forward mask kept low bits", {29'd0, fwd_out}, 32'h7);
        chk("R4 line3 not forwardable", {30'd0, parent}, 32'h1);

        // R10: enable takes effect one cycle after the write edge
        cfg_write(3'h0, 32'h0);
        drive_irq(32'h40); settle();
        chk("R9 disabled line no wake", {31'd0, wake}, 32'h0);
        cfg_write(3'h0, 32'h40); @(negedge clk); #1;
        chk("R10 old enable still seen", {30'd0, parent}, 32'h0);
        @(negedge clk); #1;
        chk("R10 new enable seen", {30'd0, parent}, 32'h2);
        chk("R9 wake on enabled line", {31'd0, wake}, 32'h1);

        // Same-cycle: forward mask rewrite while line2 rises
        cfg_write(3'h0, 32'hFFFF_FFFF);
        @(posedge clk); #2; wr = 1'b1; addr = 3'h4; wdata = 32'h0; irq = 32'h4;
        @(posedge clk); #2; wr = 1'b0;
        @(posedge clk); #2; wr = 1'b1; addr = 3'h4; wdata = 32'h4; irq = 32'h0;
        @(posedge clk); #2; wr = 1'b0; irq = 32'h4;
        settle();
        chk("R7 line2 forwarded again", {30'd0, parent}, 32'h0);

        // Mixed stimulus, judged every cycle by the monitor
        lfsr = 32'hACE1_1234;
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            @(posedge clk); #2;
            irq   = lfsr & {20'h0000F, 12'hFFF} | (lfsr[7] ? 32'hA000_0000 : 32'h0);
            wr    = (lfsr[12:10] == 3'b101);
            addr  = lfsr[14] ? 3'h4 : (lfsr[15] ? 3'h0 : lfsr[18:16]);
            wdata = {lfsr[15:0], lfsr[31:16]};
        end
        @(posedge clk); #2; wr = 1'b0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(10 * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R1 watchdog got=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule